// File: doc/BRIEF.md
# Parallel Bus Master Sequencer

This block turns a single host read or write request into one timed cycle on an external parallel bus. The cycle runs through phases in a fixed order: an optional address-latch phase when address and data share pins, a data setup phase, a strobe-active phase and a data hold phase. The length of each of the last three is programmable. While the cycle runs the block raises a busy flag. At the end it may step the stored address up or down and pulse an interrupt.

The host programs the configuration through static inputs. These select the phase lengths, how address and data share the pins, how the two chip-select pins are used, the active level of each strobe, the address step mode and whether the interrupt is enabled. The host loads a 16-bit address word: 14 address bits plus two chip-select enable bits. It starts a cycle with a one-cycle request. Read data is captured from the bus inputs and stays on a host output until the next read completes.

Top module: `pbus_master`

## Requirements
- R1: After reset the block is idle: busy and interrupt are low, the stored address word is 0, the read and write strobes and both latch strobes sit at their inactive levels, and the data bus is not driven.
- R2: A request accepted while idle raises busy on the next cycle. The strobe (read strobe for reads, write strobe for writes) becomes active after L+S busy cycles and stays active for T cycles. S is the setup code plus one (2-bit code, 1..4). T is the strobe code plus one (4-bit code, 1..16). L is the number of latch cycles from R5. The read and write strobes are never active together.
- R3: The hold phase lasts the hold code plus one cycles on a write (1..4). On a read it lasts exactly the hold code (0..3). Busy is high for L+S+T+H cycles and then drops.
- R4: Each strobe pin (read, write, low latch, high latch) and each chip-select pin used as a chip select shows its polarity bit when active and the inverse of that bit when inactive. The latch pins share one polarity bit.
- R5: Mux code 0 (separate) has no latch phase and puts address bits 13:0 on the address pins. Code 1 has one low-latch cycle with address bits 7:0 on data 7:0, and drives address bits 13:8 on address pins 13:8 with pins 7:0 at zero. Code 2 has a low-latch cycle with the address word bits 7:0 on data 7:0, followed by a high-latch cycle with bits 15:8 on data 7:0. Code 3 has one low-latch cycle with the full 16-bit address word on data 15:0. The latch pins are never active with code 0.
- R6: Chip-select function 0 drives chip-select pins 2 and 1 with the enable bits 15 and 14 of the address word, as address bits 15 and 14. Function 1 drives pin 1 as address bit 14 and uses pin 2 as a chip select. Functions 2 and 3 use both pins as chip selects. A chip select is active throughout busy when its enable bit is set. Address word bits 15 and 14 placed on the bus are the enable bits when they act as address bits, and zero otherwise.
- R7: When a cycle ends, step code 1 adds one to the 14-bit address and code 2 subtracts one, both wrapping modulo 2^14. Codes 0 and 3 leave it unchanged. The enable bits never change.
- R8: With the interrupt enabled, the interrupt output is high for exactly one cycle: the first idle cycle after a bus cycle. With it disabled the interrupt output stays low.
- R9: A request or address load presented while busy is ignored. The running cycle keeps its length, the address word is unchanged until the cycle ends, and no second cycle follows.
- R10: A write drives the request data on the data bus with output enable high during setup, strobe and hold. A read never enables the data bus during its strobe. It captures the bus input on the last strobe cycle and presents the value on the read-data output from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_setup_i | input | 2 | Setup length code (cycles minus one) |
| cfg_strobe_i | input | 4 | Strobe length code (cycles minus one) |
| cfg_hold_i | input | 2 | Hold length code |
| cfg_mux_i | input | 2 | Address/data sharing mode |
| cfg_csf_i | input | 2 | Chip-select pin function |
| cfg_step_i | input | 2 | Address step mode |
| cfg_irq_en_i | input | 1 | End-of-cycle interrupt enable |
| pol_rd_i | input | 1 | Read strobe active level |
| pol_wr_i | input | 1 | Write strobe active level |
| pol_cs1_i | input | 1 | Chip select 1 active level |
| pol_cs2_i | input | 1 | Chip select 2 active level |
| pol_al_i | input | 1 | Address latch active level |
| addr_load_i | input | 1 | Load the address word |
| addr_wdata_i | input | 16 | Address word: bit 15 enable 2, bit 14 enable 1, bits 13:0 address |
| req_valid_i | input | 1 | Start a bus cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 16 | Write data |
| addr_o | output | 16 | Current address word |
| rdata_o | output | 16 | Last captured read data |
| busy_o | output | 1 | Bus cycle in progress |
| irq_o | output | 1 | End-of-cycle interrupt pulse |
| bus_addr_o | output | 14 | Address pins |
| bus_data_o | output | 16 | Data pins, output value |
| bus_data_oe_o | output | 1 | Data pins output enable |
| bus_data_i | input | 16 | Data pins, input value |
| bus_cs1_o | output | 1 | Chip select 1 / address bit 14 |
| bus_cs2_o | output | 1 | Chip select 2 / address bit 15 |
| bus_al_lo_o | output | 1 | Low address latch strobe |
| bus_al_hi_o | output | 1 | High address latch strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |

## Verification
The assertions watch properties that hold on every cycle. The two data strobes are never active together, and a strobe is active only while busy. A read strobe never comes with a driven data bus, and the latch strobes are silent in separate mode. An idle request always starts a cycle. The address word holds steady during busy. The interrupt is a single-cycle pulse that follows a busy cycle. The exact phase lengths need the bench's scenarios, because they depend on the mux, setup, strobe and hold codes and on the read/write hold encoding. So do the latch-cycle data for each sharing mode, the chip-select function mapping, address wrap in both directions, captured read data, and the absence of a second cycle after a request made while busy.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ALO, PH_AHI, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;

  localparam logic [1:0] MUX_NONE  = 2'd0;
  localparam logic [1:0] MUX_SPLIT = 2'd1;
  localparam logic [1:0] MUX_LO8   = 2'd2;
  localparam logic [1:0] MUX_FULL  = 2'd3;

  localparam logic [1:0] CSF_ADDR2 = 2'd0;
  localparam logic [1:0] CSF_MIX   = 2'd1;

  localparam logic [1:0] STEP_INC  = 2'd1;
  localparam logic [1:0] STEP_DEC  = 2'd2;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int SW = 2,
  parameter int TW = 4,
  parameter int HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [1:0]    mux_i,
  input  logic [SW-1:0] setup_i,
  input  logic [TW-1:0] strobe_i,
  input  logic [HW-1:0] hold_i,
  output phase_e        phase_o,
  output logic          write_o,
  output logic          strobe_end_o,
  output logic          last_o
);
  localparam int CW = (TW > SW) ? ((TW > HW) ? TW : HW) : ((SW > HW) ? SW : HW);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          write_q;
  logic          cnt_zero;

  assign cnt_zero     = (cnt_q == '0);
  assign strobe_end_o = (phase_q == PH_STROBE) && cnt_zero;
  assign last_o       = (strobe_end_o && !write_q && (hold_i == '0))
                      || ((phase_q == PH_HOLD) && cnt_zero);
  assign phase_o      = phase_q;
  assign write_o      = write_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        if (mux_i != MUX_NONE) phase_d = PH_ALO;
        else begin phase_d = PH_SETUP; cnt_d = CW'(setup_i); end
      end
      PH_ALO: begin
        if (mux_i == MUX_LO8) phase_d = PH_AHI;
        else begin phase_d = PH_SETUP; cnt_d = CW'(setup_i); end
      end
      PH_AHI: begin phase_d = PH_SETUP; cnt_d = CW'(setup_i); end
      PH_SETUP: begin
        if (cnt_zero) begin phase_d = PH_STROBE; cnt_d = CW'(strobe_i); end
        else cnt_d = cnt_q - CW'(1);
      end
      PH_STROBE: begin
        if (!cnt_zero) cnt_d = cnt_q - CW'(1);
        else if (write_q) begin phase_d = PH_HOLD; cnt_d = CW'(hold_i); end
        else if (hold_i == '0) phase_d = PH_IDLE;
        else begin phase_d = PH_HOLD; cnt_d = CW'(hold_i) - CW'(1); end
      end
      PH_HOLD: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else cnt_d = cnt_q - CW'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      write_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (phase_q == PH_IDLE && start_i) write_q <= write_i;
    end
  end
endmodule

// File: rtl/pbus_addr.sv
module pbus_addr
  import pbus_pkg::*;
#(
  parameter int AW = 14,
  localparam int WW = AW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] load_data_i,
  input  logic          step_i,
  input  logic [1:0]    step_mode_i,
  input  logic [1:0]    csf_i,
  output logic [WW-1:0] reg_o,
  output logic [WW-1:0] word_o
);
  logic [AW-1:0] addr_q;
  logic          en1_q, en2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en1_q  <= 1'b0;
      en2_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= load_data_i[AW-1:0];
      en1_q  <= load_data_i[AW];
      en2_q  <= load_data_i[AW+1];
    end else if (step_i) begin
      if (step_mode_i == STEP_INC)      addr_q <= addr_q + AW'(1);
      else if (step_mode_i == STEP_DEC) addr_q <= addr_q - AW'(1);
    end
  end

  assign reg_o  = {en2_q, en1_q, addr_q};
  // pins that act as address bits also appear in the latched address word
  assign word_o = {(csf_i == CSF_ADDR2) ? en2_q : 1'b0,
                   (csf_i == CSF_ADDR2 || csf_i == CSF_MIX) ? en1_q : 1'b0,
                   addr_q};
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 16,
  localparam int WW = AW + 2
) (
  input  phase_e        phase_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [WW-1:0] reg_i,
  input  logic [WW-1:0] word_i,
  input  logic [1:0]    mux_i,
  input  logic [1:0]    csf_i,
  input  logic          pol_rd_i,
  input  logic          pol_wr_i,
  input  logic          pol_cs1_i,
  input  logic          pol_cs2_i,
  input  logic          pol_al_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          cs1_o,
  output logic          cs2_o,
  output logic          al_lo_o,
  output logic          al_hi_o,
  output logic          rd_o,
  output logic          wr_o
);
  logic busy, data_ph, en1, en2;

  assign busy    = (phase_i != PH_IDLE);
  assign data_ph = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
  assign en1     = reg_i[AW];
  assign en2     = reg_i[AW+1];

  always_comb begin
    addr_o = '0;
    if (mux_i == MUX_NONE)       addr_o = word_i[AW-1:0];
    else if (mux_i == MUX_SPLIT) addr_o[AW-1:8] = word_i[AW-1:8];
  end

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    if (phase_i == PH_ALO) begin
      data_oe_o = 1'b1;
      data_o    = (mux_i == MUX_FULL) ? DW'(word_i) : DW'(word_i[7:0]);
    end else if (phase_i == PH_AHI) begin
      data_oe_o = 1'b1;
      data_o    = DW'(word_i[WW-1:8]);
    end else if (data_ph && write_i) begin
      data_oe_o = 1'b1;
      data_o    = wdata_i;
    end
  end

  assign al_lo_o = (phase_i == PH_ALO) ? pol_al_i : ~pol_al_i;
  assign al_hi_o = (phase_i == PH_AHI) ? pol_al_i : ~pol_al_i;
  assign rd_o    = (phase_i == PH_STROBE && !write_i) ? pol_rd_i : ~pol_rd_i;
  assign wr_o    = (phase_i == PH_STROBE &&  write_i) ? pol_wr_i : ~pol_wr_i;

  assign cs2_o = (csf_i == CSF_ADDR2) ? en2
               : ((busy && en2) ? pol_cs2_i : ~pol_cs2_i);
  assign cs1_o = (csf_i == CSF_ADDR2 || csf_i == CSF_MIX) ? en1
               : ((busy && en1) ? pol_cs1_i : ~pol_cs1_i);
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 16,
  parameter int SW = 2,
  parameter int TW = 4,
  parameter int HW = 2,
  localparam int WW = AW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] cfg_setup_i,
  input  logic [TW-1:0] cfg_strobe_i,
  input  logic [HW-1:0] cfg_hold_i,
  input  logic [1:0]    cfg_mux_i,
  input  logic [1:0]    cfg_csf_i,
  input  logic [1:0]    cfg_step_i,
  input  logic          cfg_irq_en_i,
  input  logic          pol_rd_i,
  input  logic          pol_wr_i,
  input  logic          pol_cs1_i,
  input  logic          pol_cs2_i,
  input  logic          pol_al_i,
  input  logic          addr_load_i,
  input  logic [WW-1:0] addr_wdata_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [WW-1:0] addr_o,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          irq_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_data_i,
  output logic          bus_cs1_o,
  output logic          bus_cs2_o,
  output logic          bus_al_lo_o,
  output logic          bus_al_hi_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o
);
  phase_e        phase;
  logic          write, strobe_end, last, start;
  logic [WW-1:0] word;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          irq_q;

  assign busy_o = (phase != PH_IDLE);
  assign start  = req_valid_i && !busy_o;

  pbus_seq #(.SW(SW), .TW(TW), .HW(HW)) u_seq (
    .clk_i, .rst_ni,
    .start_i      (start),
    .write_i      (req_write_i),
    .mux_i        (cfg_mux_i),
    .setup_i      (cfg_setup_i),
    .strobe_i     (cfg_strobe_i),
    .hold_i       (cfg_hold_i),
    .phase_o      (phase),
    .write_o      (write),
    .strobe_end_o (strobe_end),
    .last_o       (last)
  );

  pbus_addr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .load_i      (addr_load_i && !busy_o),
    .load_data_i (addr_wdata_i),
    .step_i      (last),
    .step_mode_i (cfg_step_i),
    .csf_i       (cfg_csf_i),
    .reg_o       (addr_o),
    .word_o      (word)
  );

  pbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .phase_i   (phase),
    .write_i   (write),
    .wdata_i   (wdata_q),
    .reg_i     (addr_o),
    .word_i    (word),
    .mux_i     (cfg_mux_i),
    .csf_i     (cfg_csf_i),
    .pol_rd_i, .pol_wr_i, .pol_cs1_i, .pol_cs2_i, .pol_al_i,
    .addr_o    (bus_addr_o),
    .data_o    (bus_data_o),
    .data_oe_o (bus_data_oe_o),
    .cs1_o     (bus_cs1_o),
    .cs2_o     (bus_cs2_o),
    .al_lo_o   (bus_al_lo_o),
    .al_hi_o   (bus_al_hi_o),
    .rd_o      (bus_rd_o),
    .wr_o      (bus_wr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (start) wdata_q <= req_wdata_i;
      if (strobe_end && !write) rdata_q <= bus_data_i;
      irq_q <= last && cfg_irq_en_i;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int WW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pol_rd_i,
  input logic          pol_wr_i,
  input logic          pol_al_i,
  input logic [1:0]    cfg_mux_i,
  input logic          req_valid_i,
  input logic          busy_o,
  input logic          irq_o,
  input logic [WW-1:0] addr_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic          bus_al_lo_o,
  input logic          bus_al_hi_o,
  input logic          bus_data_oe_o
);
  logic rd_act, wr_act, al_act;
  assign rd_act = (bus_rd_o == pol_rd_i);
  assign wr_act = (bus_wr_o == pol_wr_i);
  assign al_act = (bus_al_lo_o == pol_al_i) || (bus_al_hi_o == pol_al_i);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_act && wr_act)); // R2
  AST_STROBE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act || wr_act) |-> busy_o); // R2
  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o); // R2
  AST_LATCH_MUXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_act |-> (cfg_mux_i != 2'd0)); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o))); // R8
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o)); // R9
  AST_READ_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |-> !bus_data_oe_o); // R10
endmodule

bind pbus_master pbus_master_chk #(.WW(WW)) u_chk (
  .clk_i, .rst_ni, .pol_rd_i, .pol_wr_i, .pol_al_i, .cfg_mux_i,
  .req_valid_i, .busy_o, .irq_o, .addr_o, .bus_rd_o, .bus_wr_o,
  .bus_al_lo_o, .bus_al_hi_o, .bus_data_oe_o
);

// File: tb/pbus_master_tb_top.sv
`timescale 1ns/1ps
module pbus_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] setup, hold, mux, csf, step;
  logic [3:0] strobe;
  logic irq_en, p_rd, p_wr, p_cs1, p_cs2, p_al;
  logic addr_load, req_valid, req_write;
  logic [15:0] addr_wdata, req_wdata, bus_din;
  logic [15:0] addr_o, rdata_o, bus_data_o;
  logic [13:0] bus_addr_o;
  logic busy_o, irq_o, bus_data_oe_o, bus_cs1_o, bus_cs2_o;
  logic bus_al_lo_o, bus_al_hi_o, bus_rd_o, bus_wr_o;

  pbus_master dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_setup_i(setup), .cfg_strobe_i(strobe), .cfg_hold_i(hold),
    .cfg_mux_i(mux), .cfg_csf_i(csf), .cfg_step_i(step), .cfg_irq_en_i(irq_en),
    .pol_rd_i(p_rd), .pol_wr_i(p_wr), .pol_cs1_i(p_cs1), .pol_cs2_i(p_cs2), .pol_al_i(p_al),
    .addr_load_i(addr_load), .addr_wdata_i(addr_wdata),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .addr_o, .rdata_o, .busy_o, .irq_o, .bus_addr_o, .bus_data_o, .bus_data_oe_o,
    .bus_data_i(bus_din), .bus_cs1_o, .bus_cs2_o, .bus_al_lo_o, .bus_al_hi_o,
    .bus_rd_o, .bus_wr_o
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // measurements of one bus cycle
  int m_busy, m_sstart, m_slen, m_lo_n, m_hi_n;
  logic [15:0] m_lo_data, m_hi_data, m_sdata;
  logic [13:0] m_lo_addr;
  logic m_soe, m_irq, m_cs1, m_cs2, m_both;

  task automatic run_op(input logic wr, input logic [15:0] wd, input int inj);
    m_busy = 0; m_sstart = -1; m_slen = 0; m_lo_n = 0; m_hi_n = 0;
    m_lo_data = '0; m_hi_data = '0; m_sdata = '0; m_lo_addr = '0;
    m_soe = 1'b0; m_cs1 = 1'b0; m_cs2 = 1'b0; m_both = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy_o && m_busy < 200) begin
      if (m_busy == 0) begin m_cs1 = bus_cs1_o; m_cs2 = bus_cs2_o; end
      if ((bus_rd_o == p_rd) && (bus_wr_o == p_wr)) m_both = 1'b1;
      if ((bus_rd_o == p_rd) || (bus_wr_o == p_wr)) begin
        if (m_sstart < 0) m_sstart = m_busy;
        m_slen++;
        m_sdata = bus_data_o;
        m_soe = bus_data_oe_o;
      end
      if (bus_al_lo_o == p_al) begin m_lo_n++; m_lo_data = bus_data_o; m_lo_addr = bus_addr_o; end
      if (bus_al_hi_o == p_al) begin m_hi_n++; m_hi_data = bus_data_o; end
      if (inj >= 0 && m_busy == inj) begin
        req_valid = 1'b1; req_write = ~wr; addr_load = 1'b1; addr_wdata = 16'h1234;
      end else begin
        req_valid = 1'b0; addr_load = 1'b0;
      end
      m_busy++;
      @(negedge clk);
    end
    req_valid = 1'b0; addr_load = 1'b0;
    m_irq = irq_o;
  endtask

  task automatic load_addr(input logic [15:0] a);
    @(negedge clk);
    addr_load = 1'b1; addr_wdata = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  typedef struct packed {
    logic       wr;
    logic [1:0] s;
    logic [3:0] t;
    logic [1:0] h;
    logic [1:0] mx;
    logic [7:0] busy;
  } vec_t;

  localparam vec_t VEC[8] = '{
    '{1'b1, 2'd0, 4'd0,  2'd0, 2'd0, 8'd3},
    '{1'b1, 2'd3, 4'd15, 2'd3, 2'd0, 8'd24},
    '{1'b0, 2'd0, 4'd0,  2'd0, 2'd0, 8'd2},
    '{1'b0, 2'd1, 4'd2,  2'd3, 2'd0, 8'd8},
    '{1'b1, 2'd2, 4'd4,  2'd1, 2'd1, 8'd11},
    '{1'b0, 2'd0, 4'd1,  2'd2, 2'd2, 8'd7},
    '{1'b1, 2'd1, 4'd0,  2'd0, 2'd3, 8'd5},
    '{1'b0, 2'd3, 4'd7,  2'd0, 2'd3, 8'd13}
  };

  logic watchdog_hit = 1'b0;
  initial begin
    #2000000;
    watchdog_hit = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] ea;
    logic [15:0] w16;
    int lat;
    setup = 0; strobe = 0; hold = 0; mux = 0; csf = 2'd2; step = 2'd1; irq_en = 1'b1;
    p_rd = 1'b0; p_wr = 1'b0; p_cs1 = 1'b0; p_cs2 = 1'b0; p_al = 1'b1;
    addr_load = 0; addr_wdata = 0; req_valid = 0; req_write = 0; req_wdata = 0; bus_din = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy_o && !irq_o, "R1 busy/irq", {busy_o, irq_o}, 0);
    chk(addr_o == 16'h0, "R1 addr", addr_o, 0);
    chk(bus_rd_o && bus_wr_o && !bus_al_lo_o && !bus_al_hi_o && !bus_data_oe_o,
        "R1 strobes idle", {bus_rd_o, bus_wr_o, bus_al_lo_o, bus_al_hi_o, bus_data_oe_o}, 5'b11000);

    // vector table: R2 R3 R5 R7 R8 R10
    load_addr(16'h3FFC);
    ea = 14'h3FFC;
    foreach (VEC[i]) begin
      setup = VEC[i].s; strobe = VEC[i].t; hold = VEC[i].h; mux = VEC[i].mx;
      bus_din = 16'h5A00 + 16'(i);
      lat = (VEC[i].mx == 2'd0) ? 0 : ((VEC[i].mx == 2'd2) ? 2 : 1);
      w16 = {2'b00, ea};
      run_op(VEC[i].wr, 16'hC000 + 16'(i), -1);
      chk(m_busy == int'(VEC[i].busy), $sformatf("R3 busy length v%0d", i), m_busy, VEC[i].busy);
      chk(m_sstart == lat + int'(VEC[i].s) + 1, $sformatf("R2 strobe start v%0d", i), m_sstart, lat + VEC[i].s + 1);
      chk(m_slen == int'(VEC[i].t) + 1, $sformatf("R2 strobe length v%0d", i), m_slen, VEC[i].t + 1);
      chk(!m_both, $sformatf("R2 strobe exclusive v%0d", i), m_both, 0);
      chk(m_lo_n + m_hi_n == lat, $sformatf("R5 latch count v%0d", i), m_lo_n + m_hi_n, lat);
      if (VEC[i].mx == 2'd1)
        chk(m_lo_data == {8'h00, w16[7:0]} && m_lo_addr == {w16[13:8], 8'h00},
            $sformatf("R5 split latch v%0d", i), {m_lo_data, 2'b00, m_lo_addr}, {8'h00, w16[7:0], 2'b00, w16[13:8], 8'h00});
      if (VEC[i].mx == 2'd2)
        chk(m_lo_data == {8'h00, w16[7:0]} && m_hi_data == {8'h00, w16[15:8]},
            $sformatf("R5 byte latch v%0d", i), {m_lo_data, m_hi_data}, {8'h00, w16[7:0], 8'h00, w16[15:8]});
      if (VEC[i].mx == 2'd3)
        chk(m_lo_data == w16, $sformatf("R5 full latch v%0d", i), m_lo_data, w16);
      if (VEC[i].wr)
        chk(m_soe && m_sdata == 16'hC000 + 16'(i), $sformatf("R10 write data v%0d", i), {m_soe, m_sdata}, {1'b1, 16'hC000 + 16'(i)});
      else
        chk(rdata_o == 16'h5A00 + 16'(i), $sformatf("R10 read data v%0d", i), rdata_o, 16'h5A00 + 16'(i));
      chk(m_irq, $sformatf("R8 irq pulse v%0d", i), m_irq, 1);
      ea = ea + 14'd1;
      chk(addr_o == {2'b00, ea}, $sformatf("R7 increment v%0d", i), addr_o, {2'b00, ea});
    end
    chk(addr_o == 16'h0004, "R7 wrap up", addr_o, 16'h0004);

    // R4 flipped polarities, chip selects active during busy
    p_rd = 1'b1; p_wr = 1'b1; p_cs1 = 1'b1; p_cs2 = 1'b1; p_al = 1'b0;
    csf = 2'd2; mux = 2'd0; step = 2'd0;
    load_addr(16'h4000);
    @(negedge clk);
    chk(!bus_rd_o && !bus_wr_o && bus_al_lo_o && bus_al_hi_o && !bus_cs1_o && !bus_cs2_o,
        "R4 idle levels", {bus_rd_o, bus_wr_o, bus_al_lo_o, bus_al_hi_o, bus_cs1_o, bus_cs2_o}, 6'b001100);
    setup = 0; strobe = 4'd2; hold = 0;
    run_op(1'b1, 16'h00FF, -1);
    chk(m_slen == 3 && m_sstart == 1, "R4 active-high strobe", {m_sstart[7:0], m_slen[7:0]}, {8'd1, 8'd3});
    chk(m_cs1 == 1'b1 && m_cs2 == 1'b0, "R6 cs select levels", {m_cs1, m_cs2}, 2'b10);

    // R6 function 0: both pins address bits
    p_rd = 1'b0; p_wr = 1'b0; p_cs1 = 1'b0; p_cs2 = 1'b0; p_al = 1'b1;
    csf = 2'd0; mux = 2'd3;
    load_addr(16'h8123);
    @(negedge clk);
    chk(bus_cs2_o == 1'b1 && bus_cs1_o == 1'b0, "R6 addr bits idle", {bus_cs2_o, bus_cs1_o}, 2'b10);
    run_op(1'b0, 16'h0, -1);
    chk(m_lo_data == 16'h8123, "R6 word with addr bits", m_lo_data, 16'h8123);
    chk(addr_o == 16'h8123, "R7 step none", addr_o, 16'h8123);

    // R6 function 1: pin 1 address, pin 2 chip select
    csf = 2'd1;
    load_addr(16'hC123);
    run_op(1'b0, 16'h0, -1);
    chk(m_cs1 == 1'b1 && m_cs2 == p_cs2, "R6 mixed function", {m_cs1, m_cs2}, {1'b1, p_cs2});
    chk(m_lo_data == 16'h4123, "R6 mixed word", m_lo_data, 16'h4123);

    // R7 decrement wrap; R8 disabled irq
    csf = 2'd2; mux = 2'd0; step = 2'd2; irq_en = 1'b0;
    load_addr(16'h4000);
    run_op(1'b1, 16'h1111, -1);
    chk(addr_o == 16'h7FFF, "R7 decrement wrap", addr_o, 16'h7FFF);
    chk(!m_irq, "R8 irq disabled", m_irq, 0);

    // R9 request and load while busy are ignored
    irq_en = 1'b1; step = 2'd1; setup = 2'd3; strobe = 4'd15; hold = 2'd3;
    load_addr(16'h0100);
    run_op(1'b1, 16'hBEEF, 5);
    chk(m_busy == 24, "R9 length kept", m_busy, 24);
    chk(addr_o == 16'h0101, "R9 load ignored", addr_o, 16'h0101);
    @(negedge clk);
    chk(!busy_o, "R9 no second cycle", busy_o, 0);

    if (!watchdog_hit) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule